// File: doc/BRIEF.md
# Qualified Overvoltage Fault Latch

This block watches a comparator that trips when the reflected output voltage on an auxiliary winding climbs too high, and decides when that trip is a genuine overvoltage fault rather than ringing or noise. It takes the gate-drive signal of the power switch (high while the switch conducts) and treats every high-to-low transition as a turn-off that opens a new switching cycle. After each turn-off it ignores the comparator for a fixed blanking window, which hides the leakage-inductance spike. It then accepts a comparator high only if it persists for a minimum number of clock cycles.

Accepted events are counted over consecutive switching cycles. A cycle that ends with no accepted event resets the run. When the run reaches the configured length, the block raises a latch-off output that shuts the controller down. Only a reset, which stands for removing and reapplying the supply, clears that output. A debug output shows the current run length.

Both asynchronous inputs pass through two-flop synchronizers before any other logic sees them. Blanking and minimum width are set in nanoseconds together with the clock rate. At 100 MHz the defaults give 100 blanking cycles and 60 width cycles.

Top module: `ovp_fault_latch`

## Requirements
- R1: While and after reset, `latch_off` is 0 and `event_count` is 0.
- R2: A turn-off is a 1-to-0 transition of the synchronized `gate_drv`. For BLANK_CYC cycles after a turn-off, the comparator is ignored (100 cycles at the defaults). A comparator high that lies mostly inside this window does not count.
- R3: Once blanking ends, a comparator high counts as a qualified event only if it stays high for at least MIN_WIDTH consecutive synchronized samples (60 at the defaults). A high of MIN_WIDTH-1 samples is discarded.
- R4: At most one qualified event counts per switching cycle, however long the comparator stays high.
- R5: Each qualified event raises `event_count` by one, as an unsigned binary number. A switching cycle that ends with no qualified event clears `event_count` to 0 at the turn-off that ends it. Until that turn-off, the count holds.
- R6: `latch_off` rises when the EVENTS_TO_LATCH-th consecutive qualified event (4 at the defaults) is seen. At that point `event_count` equals EVENTS_TO_LATCH.
- R7: Once `latch_off` is 1, it stays 1 and `event_count` stays frozen, whatever `cmp_in` and `gate_drv` do.
- R8: Asserting `rst_n` low is the only way to clear `latch_off` back to 0.
- R9: A new turn-off aborts any width measurement in progress. A comparator high that spans a turn-off does not qualify, and the run is cleared at the next turn-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; models a power cycle |
| gate_drv | input | 1 | Power-switch gate drive, asynchronous; a falling edge marks turn-off |
| cmp_in | input | 1 | Overvoltage comparator output, asynchronous |
| latch_off | output | 1 | Sticky fault output that shuts the controller down |
| event_count | output | $clog2(EVENTS_TO_LATCH+1) | Current count of consecutive qualified events |

## Verification
The bench probes the width threshold on both sides, at 59 and 60 samples. A design off by one there would drop genuine faults or accept slightly short glitches. It places a pulse that overlaps blanking by most of its length, which a design without blanking would count. It also sends a pulse that lasts almost the whole off-time, which a design counting per sample rather than per cycle would count several times. Runs are broken by an empty cycle and by a pulse aborted at a turn-off, which shows whether the count clears at the right turn-off. After latching, further pulses, idle cycles and a reset show whether the output is truly sticky and whether the reset really clears it.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  // Convert a time in nanoseconds to a whole number of clock cycles, rounding up.
  function automatic int ns_to_cycles(int ns, int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int bits_for(int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // A switch turn-off: conducting last cycle, off this cycle.
  function automatic logic is_turn_off(logic was_on, logic is_on);
    return was_on & ~is_on;
  endfunction

endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/ovp_qualifier.sv
module ovp_qualifier #(
  parameter int BLANK_CYC = 100,
  parameter int MIN_WIDTH = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_s,
  input  logic cmp_s,
  output logic toff,
  output logic blanking,
  output logic qual,
  output logic cycle_miss
);
  import ovp_pkg::*;

  localparam int BW = bits_for(BLANK_CYC);
  localparam int WW = bits_for(MIN_WIDTH);

  logic          gate_d;
  logic [BW-1:0] blank_cnt;
  logic [WW-1:0] width_cnt;
  logic          armed;
  logic          got_evt;
  logic          measure;

  assign toff       = is_turn_off(gate_d, gate_s);
  assign blanking   = (blank_cnt != '0);
  assign measure    = armed & ~blanking & ~got_evt & ~toff & cmp_s;
  assign qual       = measure && (width_cnt == WW'(MIN_WIDTH - 1));
  assign cycle_miss = toff & armed & ~got_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d    <= 1'b0;
      blank_cnt <= '0;
      width_cnt <= '0;
      armed     <= 1'b0;
      got_evt   <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (toff) begin
        blank_cnt <= BW'(BLANK_CYC);
        width_cnt <= '0;
        got_evt   <= 1'b0;
        armed     <= 1'b1;
      end else begin
        if (blanking) blank_cnt <= blank_cnt - 1'b1;
        if (qual) begin
          got_evt   <= 1'b1;
          width_cnt <= '0;
        end else if (measure) begin
          width_cnt <= width_cnt + 1'b1;
        end else begin
          width_cnt <= '0;
        end
      end
    end
  end

  a_r2_blank_after_toff: assert property (@(posedge clk) disable iff (!rst_n)
    toff |=> blanking);

  a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !qual);

  a_r9_abort_width: assert property (@(posedge clk) disable iff (!rst_n)
    toff |=> (width_cnt == '0));

  if (MIN_WIDTH >= 2) begin : g_hist
    a_r3_width_history: assert property (@(posedge clk) disable iff (!rst_n)
      qual |-> $past(cmp_s));
  end

endmodule

// File: rtl/ovp_event_counter.sv
module ovp_event_counter #(
  parameter int EVENTS_TO_LATCH = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     qual,
  input  logic                                     cycle_miss,
  output logic [ovp_pkg::bits_for(EVENTS_TO_LATCH)-1:0] count,
  output logic                                     latch_off
);
  import ovp_pkg::*;

  localparam int CW = bits_for(EVENTS_TO_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      latch_off <= 1'b0;
    end else if (!latch_off) begin
      if (qual) begin
        count <= count + 1'b1;
        if (count == CW'(EVENTS_TO_LATCH - 1)) latch_off <= 1'b1;
      end else if (cycle_miss) begin
        count <= '0;
      end
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(EVENTS_TO_LATCH));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !latch_off) |=> (count == $past(count) + CW'(1)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_miss && !latch_off) |=> (count == '0));

  a_r6_latch_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_off) |-> (count == CW'(EVENTS_TO_LATCH)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    latch_off |=> (latch_off && $stable(count)));

endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch #(
  parameter int CLK_MHZ         = 100,
  parameter int BLANK_NS        = 1000,
  parameter int MIN_WIDTH_NS    = 600,
  parameter int EVENTS_TO_LATCH = 4,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          gate_drv,
  input  logic                                          cmp_in,
  output logic                                          latch_off,
  output logic [ovp_pkg::bits_for(EVENTS_TO_LATCH)-1:0] event_count
);
  import ovp_pkg::*;

  localparam int BLANK_CYC = ns_to_cycles(BLANK_NS, CLK_MHZ);
  localparam int MIN_WIDTH = ns_to_cycles(MIN_WIDTH_NS, CLK_MHZ);

  logic [1:0] sync_q;
  logic       gate_s;
  logic       cmp_s;
  logic       toff;
  logic       blanking;
  logic       qual;
  logic       cycle_miss;

  ovp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({gate_drv, cmp_in}),
    .q     (sync_q)
  );

  assign gate_s = sync_q[1];
  assign cmp_s  = sync_q[0];

  ovp_qualifier #(.BLANK_CYC(BLANK_CYC), .MIN_WIDTH(MIN_WIDTH)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_s     (gate_s),
    .cmp_s      (cmp_s),
    .toff       (toff),
    .blanking   (blanking),
    .qual       (qual),
    .cycle_miss (cycle_miss)
  );

  ovp_event_counter #(.EVENTS_TO_LATCH(EVENTS_TO_LATCH)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual       (qual),
    .cycle_miss (cycle_miss),
    .count      (event_count),
    .latch_off  (latch_off)
  );

  a_r2_no_event_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blanking |=> $stable(event_count) || (event_count == '0) || latch_off);

  a_r8_no_spurious_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_off && !qual) |=> !latch_off);

endmodule

// File: tb/test_ovp_fault_latch.sv
module test_ovp_fault_latch;

  localparam int OFF_LEN  = 300;
  localparam int ON_LEN   = 40;
  localparam int LIMIT    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_drv = 1'b0;
  logic       cmp_in = 1'b0;
  logic       latch_off;
  logic [2:0] event_count;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    cnt;
    bit    lat;
    string req;
  } exp_t;

  exp_t sb[$];
  event chk_ev;

  // Bench model of the run counter.
  int m_cnt = 0;
  bit m_lat = 1'b0;
  bit m_miss = 1'b0;

  always #2.5 clk = ~clk;

  ovp_fault_latch i_ovp_fault_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_drv    (gate_drv),
    .cmp_in      (cmp_in),
    .latch_off   (latch_off),
    .event_count (event_count)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected items and compares with the outputs.
  always @(chk_ev) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (int'(event_count) != e.cnt) begin
        errors++;
        $display("FAIL %s: event_count=%0d expected %0d", e.req, event_count, e.cnt);
      end
      checks++;
      if (latch_off != e.lat) begin
        errors++;
        $display("FAIL %s: latch_off=%0b expected %0b", e.req, latch_off, e.lat);
      end
    end
  end

  task automatic expect_state(int c, bit l, string req);
    sb.push_back('{c, l, req});
    ->chk_ev;
    #0.1;
  endtask

  task automatic model_cycle(bit evt);
    if (!m_lat) begin
      if (m_miss) m_cnt = 0;
      if (evt) begin
        m_cnt++;
        m_miss = 1'b0;
        if (m_cnt == LIMIT) m_lat = 1'b1;
      end else begin
        m_miss = 1'b1;
      end
    end
  endtask

  // One switching cycle: on-time, turn-off, then an optional comparator pulse
  // starting at off-time offset pulse_at for pulse_len cycles.
  task automatic sw_cycle(int pulse_at, int pulse_len);
    gate_drv = 1'b1;
    repeat (ON_LEN) @(negedge clk);
    gate_drv = 1'b0;
    for (int t = 0; t < OFF_LEN; t++) begin
      if (pulse_len > 0 && t == pulse_at) cmp_in = 1'b1;
      if (pulse_len > 0 && t == pulse_at + pulse_len) cmp_in = 1'b0;
      @(negedge clk);
    end
    cmp_in = 1'b0;
  endtask

  task automatic run_and_check(int pulse_at, int pulse_len, bit evt, string req);
    sw_cycle(pulse_at, pulse_len);
    model_cycle(evt);
    expect_state(m_cnt, m_lat, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_state(0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_state(0, 1'b0, "R1 after reset");

    run_and_check(120, 59, 1'b0, "R3 width 59 rejected");
    run_and_check(120, 60, 1'b1, "R3 width 60 accepted");
    run_and_check(5, 140, 1'b0, "R2 pulse mostly in blanking ignored");
    run_and_check(120, 70, 1'b1, "R5 run restarts after empty cycle");
    run_and_check(110, 185, 1'b1, "R4 long pulse counts once");
    run_and_check(120, 70, 1'b1, "R5 consecutive increment");
    run_and_check(0, 0, 1'b0, "R5 count holds until next turn-off");
    run_and_check(120, 70, 1'b1, "R5 cleared by missed cycle");
    run_and_check(120, 70, 1'b1, "R5 second of new run");
    run_and_check(120, 70, 1'b1, "R6 not yet latched at 3");
    run_and_check(120, 70, 1'b1, "R6 latch at fourth event");
    run_and_check(0, 0, 1'b0, "R7 sticky through idle cycle");
    run_and_check(120, 70, 1'b1, "R7 frozen on further event");
    run_and_check(5, 290, 1'b0, "R7 sticky with comparator high");

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_lat = 1'b0; m_miss = 1'b0;
    repeat (2) @(negedge clk);
    expect_state(0, 1'b0, "R8 reset clears latch");

    run_and_check(120, 70, 1'b1, "R9 setup event");
    // Abort: comparator rises late in the off-time and spans the next turn-off.
    gate_drv = 1'b1;
    repeat (ON_LEN) @(negedge clk);
    gate_drv = 1'b0;
    for (int t = 0; t < OFF_LEN; t++) begin
      if (t == 270) cmp_in = 1'b1;
      @(negedge clk);
    end
    gate_drv = 1'b1;
    repeat (20) @(negedge clk);
    gate_drv = 1'b0;
    for (int t = 0; t < OFF_LEN; t++) begin
      if (t == 30) cmp_in = 1'b0;
      @(negedge clk);
    end
    expect_state(0, 1'b0, "R9 aborted width not counted");
    m_cnt = 0; m_miss = 1'b1;
    run_and_check(120, 70, 1'b1, "R9 fresh run after abort");

    repeat (2) @(negedge clk);
    ->chk_ev;
    #0.1;
    finish_run();
  end

endmodule